// File: doc/BRIEF.md
# Serializing Issue Queue Occupancy And Squash Tracker

This block keeps the occupancy state of a fixed pool of instruction-queue slots. Every slot holds a live bit, a 16-bit program-order tag, a flag telling whether the instruction must wait for the retirement stage (serializing), and a flag recording that such a wait has been lifted. Dispatch writes new instructions into the lowest free slot. The block reports how many slots are free and whether the pool is full. It also gives a per-slot mask of the entries that are eligible to be picked.

Serializing entries sit in the pool without being eligible. Retirement lifts the wait by presenting the entry's tag on the release port, and from then on the entry is treated like any ordinary ready entry. When a misprediction is resolved, the squash port names a tag. Every live slot holding a younger instruction (a strictly larger tag) is emptied, and the emptied slots are reported for one cycle so the retirement side can drop them. The issue port removes a picked slot from the pool. Wakeup, pick policy and memory ordering live outside this block.

Top module: `iqs_top`

## Requirements
- R1: After reset `free_cnt` equals ENTRIES, `full` is 0, and `ready_mask`, `kill_mask`, `ovf_err` and `rel_err` are all 0.
- R2: An accepted insert takes the lowest-numbered free slot, which is shown on `alloc_slot`. An accepted insert lowers `free_cnt` by one at the next edge, and each issued or squashed slot raises it by one.
- R3: `full` is 1 exactly when `free_cnt` is 0. An insert while full is dropped and raises `ovf_err` for the following cycle.
- R4: An entry inserted with `ins_serial`=1 has its `ready_mask` bit at 0 until a release carrying its tag arrives. From the edge after that release the bit is 1.
- R5: A squash with tag S empties exactly the live slots whose tag is strictly greater than S. A slot whose tag equals S survives.
- R6: A squash never counts a slot that is empty or that is issued in the same cycle. `kill_mask` shows, in the cycle after the squash, one bit per slot the squash emptied (bit i = slot i).
- R7: A squashed serializing entry leaves the set waiting for release, so a later release of its tag is treated as unknown.
- R8: A squash while the pool is empty changes nothing: `kill_mask` stays 0 and `free_cnt` stays at ENTRIES.
- R9: A release whose tag matches no live, still-waiting serializing entry raises `rel_err` for the following cycle and changes no state.
- R10: An issue request naming a slot whose `ready_mask` bit is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_serial | input | 1 | The inserted entry must wait for release |
| ins_seq | input | 16 | Tag of the inserted entry |
| alloc_slot | output | 3 | Slot the next insert will occupy |
| iss_valid | input | 1 | Issue request |
| iss_slot | input | 3 | Slot being issued |
| rel_valid | input | 1 | Release request from retirement |
| rel_seq | input | 16 | Tag being released |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 16 | Squash boundary tag; younger entries are removed |
| free_cnt | output | 4 | Number of empty slots |
| full | output | 1 | No empty slot remains |
| ready_mask | output | 8 | Slots eligible to issue |
| kill_mask | output | 8 | Slots emptied by the previous cycle's squash |
| ovf_err | output | 1 | Previous cycle attempted an insert while full |
| rel_err | output | 1 | Previous cycle released an unknown tag |

## Verification
Some properties are checked on every cycle. These are the one-step drop in free count after a lone insert, the full/overflow relation, the blocking of a freshly inserted serializing entry, the link between squash and kill reports, the empty-pool squash, and the cause of release errors. Other behaviour can only be shown by the directed scenarios. These scenarios cover the exact tag boundary of a squash, an issue and a squash colliding in the same cycle, the loss of a pending release after its entry is squashed, and the lowest-slot allocation order.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

    parameter int SEQ_W = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic live;
        logic serial;
        logic released;
        seq_t seq;
    } slot_t;

    // true when tag a is younger than tag b (no wrap handling)
    function automatic logic is_younger(input seq_t a, input seq_t b);
        return a > b;
    endfunction

endpackage

// File: rtl/iqs_alloc.sv
module iqs_alloc #(
    parameter int N = 8,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  free_vec,
    output logic          any_free,
    output logic [SW-1:0] slot
);
    always_comb begin
        any_free = 1'b0;
        slot     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                any_free = 1'b1;
                slot     = SW'(i);
            end
        end
    end
endmodule

// File: rtl/iqs_entry.sv
module iqs_entry
    import iqs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  load_serial,
    input  seq_t  load_seq,
    input  logic  iss_sel,
    input  logic  rel_valid,
    input  seq_t  rel_seq,
    input  logic  sq_valid,
    input  seq_t  sq_seq,
    output logic  live_o,
    output logic  ready_o,
    output logic  kill_o,
    output logic  rel_hit_o
);
    slot_t st;
    logic  issue_fire;

    assign live_o     = st.live;
    assign ready_o    = st.live && (!st.serial || st.released);
    assign issue_fire = iss_sel && ready_o;
    assign kill_o     = sq_valid && st.live && is_younger(st.seq, sq_seq) && !issue_fire;
    assign rel_hit_o  = rel_valid && st.live && st.serial && !st.released && (st.seq == rel_seq);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (load) begin
            st.live     <= 1'b1;
            st.serial   <= load_serial;
            st.released <= 1'b0;
            st.seq      <= load_seq;
        end else if (kill_o || issue_fire) begin
            st.live <= 1'b0;
        end else if (rel_hit_o) begin
            st.released <= 1'b1;
        end
    end
endmodule

// File: rtl/iqs_top.sv
module iqs_top
    import iqs_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int SW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CW = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_valid,
    input  logic               ins_serial,
    input  logic [SEQ_W-1:0]   ins_seq,
    output logic [SW-1:0]      alloc_slot,
    input  logic               iss_valid,
    input  logic [SW-1:0]      iss_slot,
    input  logic               rel_valid,
    input  logic [SEQ_W-1:0]   rel_seq,
    input  logic               sq_valid,
    input  logic [SEQ_W-1:0]   sq_seq,
    output logic [CW-1:0]      free_cnt,
    output logic               full,
    output logic [ENTRIES-1:0] ready_mask,
    output logic [ENTRIES-1:0] kill_mask,
    output logic               ovf_err,
    output logic               rel_err
);
    logic [ENTRIES-1:0] live_vec;
    logic [ENTRIES-1:0] kill_vec;
    logic [ENTRIES-1:0] hit_vec;
    logic               any_free;
    logic               accept;

    iqs_alloc #(.N(ENTRIES)) u_alloc (
        .free_vec (~live_vec),
        .any_free (any_free),
        .slot     (alloc_slot)
    );

    assign accept = ins_valid && any_free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        iqs_entry u_ent (
            .clk         (clk),
            .rst         (rst),
            .load        (accept && (alloc_slot == SW'(g))),
            .load_serial (ins_serial),
            .load_seq    (ins_seq),
            .iss_sel     (iss_valid && (iss_slot == SW'(g))),
            .rel_valid   (rel_valid),
            .rel_seq     (rel_seq),
            .sq_valid    (sq_valid),
            .sq_seq      (sq_seq),
            .live_o      (live_vec[g]),
            .ready_o     (ready_mask[g]),
            .kill_o      (kill_vec[g]),
            .rel_hit_o   (hit_vec[g])
        );
    end

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            free_cnt = free_cnt + CW'(!live_vec[i]);
        end
    end

    assign full = !any_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            kill_mask <= '0;
            ovf_err   <= 1'b0;
            rel_err   <= 1'b0;
        end else begin
            kill_mask <= kill_vec;
            ovf_err   <= ins_valid && !any_free;
            rel_err   <= rel_valid && (hit_vec == '0);
        end
    end
endmodule

// File: rtl/iqs_chk.sv
module iqs_chk #(
    parameter int N = 8,
    parameter int SW = 3,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ins_valid,
    input logic          ins_serial,
    input logic          iss_valid,
    input logic          rel_valid,
    input logic          sq_valid,
    input logic [SW-1:0] alloc_slot,
    input logic [CW-1:0] free_cnt,
    input logic          full,
    input logic [N-1:0]  ready_mask,
    input logic [N-1:0]  kill_mask,
    input logic          ovf_err,
    input logic          rel_err
);
    AST_LONE_INSERT_DROP: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !full && !iss_valid && !sq_valid) |=> (free_cnt == $past(free_cnt) - 1'b1)); // R2

    AST_FULL_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && full) |=> ovf_err); // R3

    AST_FULL_ZERO: assert property (@(posedge clk) disable iff (rst)
        full |-> (free_cnt == '0)); // R3

    AST_SERIAL_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !full && ins_serial) |=> !ready_mask[$past(alloc_slot)]); // R4

    AST_KILL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (kill_mask != '0) |-> $past(sq_valid)); // R6

    AST_EMPTY_SQUASH: assert property (@(posedge clk) disable iff (rst)
        (sq_valid && free_cnt == CW'(N)) |=> (kill_mask == '0)); // R8

    AST_REL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rel_err |-> $past(rel_valid)); // R9
endmodule

bind iqs_top iqs_chk #(.N(ENTRIES), .SW(SW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ins_valid  (ins_valid),
    .ins_serial (ins_serial),
    .iss_valid  (iss_valid),
    .rel_valid  (rel_valid),
    .sq_valid   (sq_valid),
    .alloc_slot (alloc_slot),
    .free_cnt   (free_cnt),
    .full       (full),
    .ready_mask (ready_mask),
    .kill_mask  (kill_mask),
    .ovf_err    (ovf_err),
    .rel_err    (rel_err)
);

// File: tb/iqs_top_test.sv
module iqs_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 0, ins_serial = 0;
    logic [15:0] ins_seq = 0;
    logic [2:0]  alloc_slot;
    logic        iss_valid = 0;
    logic [2:0]  iss_slot = 0;
    logic        rel_valid = 0;
    logic [15:0] rel_seq = 0;
    logic        sq_valid = 0;
    logic [15:0] sq_seq = 0;
    logic [3:0]  free_cnt;
    logic        full;
    logic [7:0]  ready_mask, kill_mask;
    logic        ovf_err, rel_err;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    iqs_top uut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_serial(ins_serial), .ins_seq(ins_seq),
        .alloc_slot(alloc_slot),
        .iss_valid(iss_valid), .iss_slot(iss_slot),
        .rel_valid(rel_valid), .rel_seq(rel_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .free_cnt(free_cnt), .full(full),
        .ready_mask(ready_mask), .kill_mask(kill_mask),
        .ovf_err(ovf_err), .rel_err(rel_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ins_valid = 0; iss_valid = 0; rel_valid = 0; sq_valid = 0;
    endtask

    task automatic do_insert(input logic serial, input int seq);
        ins_valid = 1; ins_serial = serial; ins_seq = 16'(seq);
        tick();
    endtask

    task automatic do_issue(input int slot);
        iss_valid = 1; iss_slot = 3'(slot);
        tick();
    endtask

    task automatic do_release(input int seq);
        rel_valid = 1; rel_seq = 16'(seq);
        tick();
    endtask

    task automatic do_squash(input int seq);
        sq_valid = 1; sq_seq = 16'(seq);
        tick();
    endtask

    task automatic t_reset();
        check("R1", "free_cnt", free_cnt, 8);
        check("R1", "full", full, 0);
        check("R1", "ready_mask", ready_mask, 0);
        check("R1", "kill_mask", kill_mask, 0);
        check("R1", "errors", {ovf_err, rel_err}, 0);
    endtask

    task automatic t_insert_issue();
        check("R2", "alloc_slot empty", alloc_slot, 0);
        do_insert(0, 10);
        do_insert(0, 11);
        do_insert(0, 12);
        check("R2", "free after 3 inserts", free_cnt, 5);
        check("R2", "ready after 3 inserts", ready_mask, 8'b0000_0111);
        do_issue(1);
        check("R2", "free after issue", free_cnt, 6);
        check("R2", "ready after issue", ready_mask, 8'b0000_0101);
        check("R2", "alloc_slot lowest hole", alloc_slot, 1);
        do_issue(5);
        check("R10", "issue of empty slot free", free_cnt, 6);
        check("R10", "issue of empty slot ready", ready_mask, 8'b0000_0101);
    endtask

    task automatic t_serial();
        do_insert(1, 13);
        check("R4", "serial not ready", ready_mask, 8'b0000_0101);
        check("R2", "free after serial insert", free_cnt, 5);
        do_issue(1);
        check("R10", "issue of blocked serial free", free_cnt, 5);
        do_release(13);
        check("R4", "serial ready after release", ready_mask, 8'b0000_0111);
        check("R9", "known release no error", rel_err, 0);
        do_release(99);
        check("R9", "unknown release error", rel_err, 1);
        check("R9", "unknown release no state change", ready_mask, 8'b0000_0111);
        tick();
        check("R9", "error is one cycle", rel_err, 0);
    endtask

    task automatic t_squash_basic();
        do_squash(11);
        check("R5", "kill_mask younger than 11", kill_mask, 8'b0000_0110);
        check("R5", "free after squash", free_cnt, 7);
        check("R5", "ready after squash", ready_mask, 8'b0000_0001);
        tick();
        check("R6", "kill_mask one cycle", kill_mask, 0);
    endtask

    task automatic t_squash_serial();
        do_insert(1, 20);
        do_squash(15);
        check("R7", "serial squashed", kill_mask, 8'b0000_0010);
        check("R7", "free after serial squash", free_cnt, 7);
        do_release(20);
        check("R7", "release after squash is unknown", rel_err, 1);
        check("R7", "ready unchanged", ready_mask, 8'b0000_0001);
    endtask

    task automatic t_squash_empty();
        do_issue(0);
        check("R2", "pool empty", free_cnt, 8);
        do_squash(0);
        check("R8", "empty squash kill", kill_mask, 0);
        check("R8", "empty squash free", free_cnt, 8);
    endtask

    task automatic t_full_and_boundary();
        for (int i = 1; i <= 8; i++) do_insert(0, i);
        check("R3", "full set", full, 1);
        check("R3", "free zero", free_cnt, 0);
        do_insert(0, 9);
        check("R3", "overflow error", ovf_err, 1);
        check("R3", "overflow dropped", ready_mask, 8'hFF);
        do_squash(4);
        check("R5", "boundary tag survives", kill_mask, 8'hF0);
        check("R5", "free after boundary squash", free_cnt, 4);
        check("R3", "not full", full, 0);
        iss_valid = 1; iss_slot = 3'd0;
        sq_valid = 1; sq_seq = 16'd0;
        tick();
        check("R6", "issued slot not counted", kill_mask, 8'b0000_1110);
        check("R6", "free after collision", free_cnt, 8);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst = 0;
                t_reset();
                t_insert_issue();
                t_serial();
                t_squash_basic();
                t_squash_serial();
                t_squash_empty();
                t_full_and_boundary();
            end
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule